// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counting Timer

A memory-mapped timer peripheral built from one shared 16-bit prescaler and a parameterized number of 32-bit down-counting channels. The prescaler counts down on every clock. When it reaches zero it emits a one-cycle tick and restarts from its reload value, so ticks arrive once every (reload + 1) clocks. Every enabled channel decrements on each tick. A channel expires on the tick after its counter has reached zero (underflow). On expiry it may raise a sticky pending flag and a one-cycle pulse on its own interrupt line. It then either reloads and keeps running or stops.

Software reaches the block through a plain single-cycle register port: a word address, a write strobe, write data, and combinational read data for the addressed word. The port has no handshake. A write takes effect at the clock edge where the strobe is high. Read data always reflects the current register state at the presented address. The port carries word addresses (byte offset divided by 4). Byte offsets below are given for reference.

Top module: `ptmr_unit`

## Requirements
- R1: After reset, the prescaler value and reload read 0, and every channel's counter, reload and control read 0. No interrupt line is high.
- R2: The prescaler value (byte offset 0x00) and prescaler reload (0x04) keep only write-data bits [15:0]. Upper bits are dropped, and reads return the stored 16 bits zero-extended.
- R3: The prescaler value decrements by one per clock. In a cycle where it is zero, a tick is produced and the value is reloaded from the prescaler reload. Ticks therefore occur once every (reload + 1) clocks. A write to offset 0x00 sets the value directly.
- R4: Channel n has its window at byte offset 0x10 + 0x10*n: counter at +0, reload at +4, control at +8. An enabled channel (control bit0 = 1) decrements its counter on each tick. A counter loaded with N expires on the (N+1)-th tick.
- R5: On expiry with interrupt enable (control bit3) set, the channel sets its pending flag (control bit4). Its interrupt line is high for exactly the cycle after the expiring edge. Without interrupt enable, neither happens.
- R6: On expiry with restart (control bit1) set, the counter is reloaded from the channel reload and counting continues. Without restart, the enable bit is cleared and the counter stays at 0.
- R7: A control write stores bits 0, 1 and 3 as written. Bit4 = 1 clears the pending flag, while bit4 = 0 leaves it unchanged. Bits 5 and 6 are not stored and read 0.
- R8: A control write with bit2 (load) = 1 copies the channel reload into the counter. Bit2 always reads 0.
- R9: Offset 0x08 reads the capability word:
  - bits [2:0] hold the channel count modulo 8;
  - bits [7:3] hold the interrupt base number;
  - bit8 and bit9 read 1;
  - all other bits read 0.
- R10: Writes to offset 0x08, to any +0xC slot, and to windows of nonexistent channels are ignored. Reads from the +0xC slots and from those windows return 0.
- R11: A write to any register of a channel makes that channel ignore a tick arriving in the same cycle. The write's effect stands, and no decrement or expiry happens on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_word | input | ADDR_W-2 | Word address (byte offset >> 2) |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed word (combinational) |
| irq_o | output | NCH | One interrupt pulse line per channel |

## Verification
The hardest situations to reach from the ports are collisions. One is a register write landing on the exact edge where an enabled channel at zero would expire. Another is a pending-clear coinciding with expiry, or a channel underflowing every tick with a reload of zero. The stimulus forces these collisions to happen often. It keeps the prescaler reload between 0 and 3 and channel counts and reloads small. It then issues random writes across every window and slot, checking each cycle's read data and interrupt vector against a cycle-level model in the bench. Directed sequences first pin down the exact underflow period, the tick spacing, the restart pulse train and the write-over-tick priority.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;

  // Slot within a 16-byte register window (word address bits [1:0])
  typedef enum logic [1:0] {
    SLOT_CNT = 2'd0,
    SLOT_RLD = 2'd1,
    SLOT_CTL = 2'd2,
    SLOT_GAP = 2'd3
  } slot_e;

  // Control bit positions
  localparam int CB_EN  = 0;
  localparam int CB_RS  = 1;
  localparam int CB_LD  = 2;
  localparam int CB_IE  = 3;
  localparam int CB_IP  = 4;
  localparam int CTL_W  = 5;

  function automatic logic [31:0] cap_word(input int nch, input int irq_base);
    logic [31:0] w;
    w       = '0;
    w[2:0]  = 3'(nch);
    w[7:3]  = 5'(irq_base);
    w[8]    = 1'b1;
    w[9]    = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_val,
  input  logic          wr_rld,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] val_o,
  output logic [PW-1:0] rld_o,
  output logic          tick_o
);

  logic [PW-1:0] val_q;
  logic [PW-1:0] rld_q;

  assign tick_o = (val_q == '0);
  assign val_o  = val_q;
  assign rld_o  = rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_val)
        val_q <= wdata;
      else if (tick_o)
        val_q <= rld_q;
      else
        val_q <= val_q - 1'b1;

      if (wr_rld)
        rld_q <= wdata;
    end
  end

endmodule

// File: rtl/ptmr_decode.sv
`timescale 1ns/1ps
module ptmr_decode
  import ptmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int WA  = 6
) (
  input  logic [WA-1:0]  word,
  input  logic           wr,
  output logic           unit_hit,
  output slot_e          slot,
  output logic [NCH-1:0] ch_hit,
  output logic           u_wr_val,
  output logic           u_wr_rld,
  output logic [NCH-1:0] wr_cnt,
  output logic [NCH-1:0] wr_rld,
  output logic [NCH-1:0] wr_ctl
);

  localparam int WW = WA - 2;

  logic [WW-1:0] win;

  assign win      = word[WA-1:2];
  assign slot     = slot_e'(word[1:0]);
  assign unit_hit = (win == '0);
  assign u_wr_val = wr && unit_hit && (slot == SLOT_CNT);
  assign u_wr_rld = wr && unit_hit && (slot == SLOT_RLD);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_hit[i] = (win == WW'(i + 1));
    assign wr_cnt[i] = wr && ch_hit[i] && (slot == SLOT_CNT);
    assign wr_rld[i] = wr && ch_hit[i] && (slot == SLOT_RLD);
    assign wr_ctl[i] = wr && ch_hit[i] && (slot == SLOT_CTL);
  end

endmodule

// File: rtl/ptmr_channel.sv
`timescale 1ns/1ps
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic             wr_ctl,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    rld_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o,
  output logic             exp_o,
  output logic             en_o,
  output logic             rs_o,
  output logic             ie_o,
  output logic             pend_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rld_q;
  logic          en_q;
  logic          rs_q;
  logic          ie_q;
  logic          pend_q;
  logic          irq_q;
  logic          any_wr;
  logic          live_tick;

  assign any_wr    = wr_cnt || wr_rld || wr_ctl;
  assign live_tick = tick && en_q && !any_wr;
  assign exp_o     = live_tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      rs_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= exp_o && ie_q;

      if (wr_cnt)
        cnt_q <= wdata;

      if (wr_rld)
        rld_q <= wdata;

      if (wr_ctl) begin
        en_q <= wdata[CB_EN];
        rs_q <= wdata[CB_RS];
        ie_q <= wdata[CB_IE];
        if (wdata[CB_IP])
          pend_q <= 1'b0;
        if (wdata[CB_LD])
          cnt_q <= rld_q;
      end else if (live_tick) begin
        if (cnt_q == '0) begin
          if (ie_q)
            pend_q <= 1'b1;
          if (rs_q)
            cnt_q <= rld_q;
          else
            en_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign irq_o  = irq_q;
  assign en_o   = en_q;
  assign rs_o   = rs_q;
  assign ie_o   = ie_q;
  assign pend_o = pend_q;

  always_comb begin
    ctl_o         = '0;
    ctl_o[CB_EN]  = en_q;
    ctl_o[CB_RS]  = rs_q;
    ctl_o[CB_IE]  = ie_q;
    ctl_o[CB_IP]  = pend_q;
  end

endmodule

// File: rtl/ptmr_unit.sv
`timescale 1ns/1ps
module ptmr_unit
  import ptmr_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int IRQ_BASE = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PW       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-3:0] reg_word,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    irq_o
);

  localparam int WA = ADDR_W - 2;
  localparam logic [DATA_W-1:0] CAP = DATA_W'(cap_word(NCH, IRQ_BASE));

  logic              unit_hit;
  slot_e             slot;
  logic [NCH-1:0]    ch_hit;
  logic              u_wr_val;
  logic              u_wr_rld;
  logic [NCH-1:0]    wr_cnt;
  logic [NCH-1:0]    wr_rld;
  logic [NCH-1:0]    wr_ctl;
  logic              tick;
  logic [PW-1:0]     presc_val;
  logic [PW-1:0]     presc_rld;
  logic [DATA_W-1:0] ch_cnt [NCH];
  logic [DATA_W-1:0] ch_rld [NCH];
  logic [CTL_W-1:0]  ch_ctl [NCH];
  logic [NCH-1:0]    ch_exp;
  logic [NCH-1:0]    ch_en;
  logic [NCH-1:0]    ch_rs;
  logic [NCH-1:0]    ch_ie;
  logic [NCH-1:0]    ch_pend;

  ptmr_decode #(.NCH(NCH), .WA(WA)) u_dec (
    .word     (reg_word),
    .wr       (reg_wr),
    .unit_hit (unit_hit),
    .slot     (slot),
    .ch_hit   (ch_hit),
    .u_wr_val (u_wr_val),
    .u_wr_rld (u_wr_rld),
    .wr_cnt   (wr_cnt),
    .wr_rld   (wr_rld),
    .wr_ctl   (wr_ctl)
  );

  ptmr_prescaler #(.PW(PW)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_val (u_wr_val),
    .wr_rld (u_wr_rld),
    .wdata  (reg_wdata[PW-1:0]),
    .val_o  (presc_val),
    .rld_o  (presc_rld),
    .tick_o (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ptmr_channel #(.CW(DATA_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_cnt (wr_cnt[i]),
      .wr_rld (wr_rld[i]),
      .wr_ctl (wr_ctl[i]),
      .wdata  (reg_wdata),
      .cnt_o  (ch_cnt[i]),
      .rld_o  (ch_rld[i]),
      .ctl_o  (ch_ctl[i]),
      .irq_o  (irq_o[i]),
      .exp_o  (ch_exp[i]),
      .en_o   (ch_en[i]),
      .rs_o   (ch_rs[i]),
      .ie_o   (ch_ie[i]),
      .pend_o (ch_pend[i])
    );
  end

  // Read mux: unit window, then channel windows; everything else reads 0
  always_comb begin
    reg_rdata = '0;
    if (unit_hit) begin
      case (slot)
        SLOT_CNT: reg_rdata = DATA_W'(presc_val);
        SLOT_RLD: reg_rdata = DATA_W'(presc_rld);
        SLOT_CTL: reg_rdata = CAP;
        default:  reg_rdata = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (slot)
          SLOT_CNT: reg_rdata = ch_cnt[i];
          SLOT_RLD: reg_rdata = ch_rld[i];
          SLOT_CTL: reg_rdata = DATA_W'(ch_ctl[i]);
          default:  reg_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ptmr_checks.sv
`timescale 1ns/1ps
module ptmr_checks #(
  parameter int NCH      = 2,
  parameter int IRQ_BASE = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PW       = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-3:0] reg_word,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NCH-1:0]    irq_o,
  input logic              tick,
  input logic [PW-1:0]     presc_val,
  input logic [PW-1:0]     presc_rld,
  input logic [NCH-1:0]    ch_exp,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_rs,
  input logic [NCH-1:0]    ch_ie,
  input logic [NCH-1:0]    ch_pend
);

  localparam int WW = ADDR_W - 4;
  localparam logic [DATA_W-1:0] CAP_EXP = DATA_W'(ptmr_pkg::cap_word(NCH, IRQ_BASE));

  logic [WW-1:0] win;
  logic [1:0]    slot;
  assign win  = reg_word[ADDR_W-3:2];
  assign slot = reg_word[1:0];

  // R3: after a tick with no value write, the value restarts from the reload
  p_presc_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && !$past(reg_wr && reg_word == '0)) |-> (presc_val == $past(presc_rld)));

  // R9: capability word at the unit control slot
  p_cap_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win == '0 && slot == 2'd2) |-> (reg_rdata == CAP_EXP));

  // R8: load bit never reads back set in a channel control slot
  p_load_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0 && slot == 2'd2) |-> !reg_rdata[2]);

  // R10: nonexistent channel windows read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win > WW'(NCH)) |-> (reg_rdata == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_prop
    // R5: an interrupt pulse comes with the pending flag set
    p_irq_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> ch_pend[i]);

    // R5: an interrupt pulse needs interrupt enable in the expiring cycle
    p_irq_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> $past(ch_ie[i]));

    // R6: expiry without restart stops the channel
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_exp[i] && !ch_rs[i]) |-> !ch_en[i]);
  end

endmodule

bind ptmr_unit ptmr_checks #(
  .NCH(NCH), .IRQ_BASE(IRQ_BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW(PW)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_word  (reg_word),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .tick      (tick),
  .presc_val (presc_val),
  .presc_rld (presc_rld),
  .ch_exp    (ch_exp),
  .ch_en     (ch_en),
  .ch_rs     (ch_rs),
  .ch_ie     (ch_ie),
  .ch_pend   (ch_pend)
);

// File: tb/ptmr_unit_bench.sv
`timescale 1ns/1ps
module ptmr_unit_bench;

  localparam int NCH = 3;
  localparam int IRQB = 5;
  localparam logic [31:0] CAP = 32'h0000_032B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_word = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] irq_o;

  always #10 clk = ~clk;

  ptmr_unit #(.NCH(NCH), .IRQ_BASE(IRQB)) u_ptmr_unit (
    .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  int unsigned m_pv, m_pr;
  int unsigned m_cnt [NCH];
  int unsigned m_rld [NCH];
  bit m_en [NCH], m_rs [NCH], m_ie [NCH], m_pd [NCH];
  logic [NCH-1:0] m_irq;
  logic [31:0] last_rd;
  logic [NCH-1:0] last_irq;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int w = a >> 4;
    int s = (a >> 2) & 3;
    if (w == 0) begin
      if (s == 0) return m_pv;
      if (s == 1) return m_pr;
      if (s == 2) return CAP;
      return 0;
    end
    if (w <= NCH) begin
      if (s == 0) return m_cnt[w-1];
      if (s == 1) return m_rld[w-1];
      if (s == 2) return {27'd0, m_pd[w-1], m_ie[w-1], 1'b0, m_rs[w-1], m_en[w-1]};
    end
    return 0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    int w = a >> 4;
    int s = (a >> 2) & 3;
    if (w == 0 && s < 2) return "R2/R3 prescaler";
    if (w == 0 && s == 2) return "R9 capability";
    if (w > NCH || s == 3) return "R10 unmapped";
    if (s == 0) return "R4 counter";
    if (s == 1) return "R8 reload";
    return "R7 control";
  endfunction

  task automatic model_edge(input logic [7:0] a, input bit wr, input logic [31:0] d);
    int w = a >> 4;
    int s = (a >> 2) & 3;
    bit tk = (m_pv == 0);
    logic [NCH-1:0] nirq = '0;
    if (wr && w == 0 && s == 0) m_pv = d[15:0];
    else if (tk) m_pv = m_pr;
    else m_pv = m_pv - 1;
    if (wr && w == 0 && s == 1) m_pr = d[15:0];
    for (int i = 0; i < NCH; i++) begin
      bit hit = wr && (w == i + 1) && (s != 3);
      if (hit) begin
        if (s == 0) m_cnt[i] = d;
        else if (s == 1) m_rld[i] = d;
        else begin
          m_en[i] = d[0]; m_rs[i] = d[1]; m_ie[i] = d[3];
          if (d[4]) m_pd[i] = 0;
          if (d[2]) m_cnt[i] = m_rld[i];
        end
      end else if (tk && m_en[i]) begin
        if (m_cnt[i] == 0) begin
          nirq[i] = m_ie[i];
          if (m_ie[i]) m_pd[i] = 1;
          if (m_rs[i]) m_cnt[i] = m_rld[i];
          else m_en[i] = 0;
        end else m_cnt[i] = m_cnt[i] - 1;
      end
    end
    m_irq = nirq;
  endtask

  // one bus cycle: drive, sample before the edge, advance model at the edge
  task automatic step(input logic [7:0] a, input bit wr, input logic [31:0] d);
    reg_word = a[7:2]; reg_wr = wr; reg_wdata = d;
    #5;
    last_rd = reg_rdata;
    last_irq = irq_o;
    check(tag_of(a), last_rd, model_read(a));
    check("R5 irq vector", {29'd0, last_irq}, {29'd0, m_irq});
    @(posedge clk);
    model_edge(a, wr, d);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int n;
    void'($urandom(32'd20240611));
    m_pv = 0; m_pr = 0; m_irq = '0;
    for (int i = 0; i < NCH; i++) begin
      m_cnt[i] = 0; m_rld[i] = 0; m_en[i] = 0; m_rs[i] = 0; m_ie[i] = 0; m_pd[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R9 reset state and capability
    step(8'h08, 0, 0); check("R9 capability", last_rd, CAP);
    step(8'h18, 0, 0); check("R1 ctl reset", last_rd, 0);
    step(8'h14, 0, 0); check("R1 rld reset", last_rd, 0);
    step(8'h04, 0, 0); check("R1 presc reset", last_rd, 0);
    check("R1 irq reset", {29'd0, last_irq}, 0);

    // R2 upper bits dropped
    step(8'h04, 1, 32'hFFFF_0003);
    step(8'h04, 0, 0); check("R2 reload width", last_rd, 32'h3);
    step(8'h04, 1, 0);
    step(8'h00, 1, 0);

    // R8 load, R4 period, R5/R6 one-shot with interrupt
    step(8'h14, 1, 5);
    step(8'h18, 1, 32'hD);
    step(8'h10, 0, 0); check("R8 load copies reload", last_rd, 5);
    step(8'h18, 0, 0); check("R8 load reads zero", last_rd, 32'h09);
    k = 3;
    while (k < 30) begin
      step(8'h18, 0, 0);
      if (last_irq[0]) break;
      k++;
    end
    check("R4 period N+1 ticks", k, 7);
    step(8'h18, 0, 0); check("R6 stop and R5 pending", last_rd, 32'h18);
    check("R5 single-cycle pulse", {31'd0, last_irq[0]}, 0);

    // R7 pending write semantics
    step(8'h18, 1, 32'h08); step(8'h18, 0, 0); check("R7 pending kept", last_rd, 32'h18);
    step(8'h18, 1, 32'h18); step(8'h18, 0, 0); check("R7 pending cleared", last_rd, 32'h08);
    step(8'h18, 1, 32'h60); step(8'h18, 0, 0); check("R7 bits5-6 dropped", last_rd, 32'h00);

    // R6 restart pulse train, period 3 ticks
    step(8'h24, 1, 2);
    step(8'h28, 1, 32'hF);
    n = 0;
    for (int j = 0; j < 12; j++) begin
      step(8'h20, 0, 0);
      n += int'(last_irq[1]);
    end
    check("R6 restart pulses", n, 3);
    step(8'h28, 1, 32'h10);

    // R11 writes win over ticks
    step(8'h30, 1, 9);
    step(8'h38, 1, 1);
    repeat (3) step(8'h34, 1, 0);
    step(8'h30, 0, 0); check("R11 writes block tick", last_rd, 9);
    step(8'h30, 0, 0); check("R11 resumes after writes", last_rd, 8);
    step(8'h38, 1, 0);

    // R10 ignored writes and zero reads
    step(8'h08, 1, 32'hFFFF_FFFF); step(8'h08, 0, 0); check("R10 cap write ignored", last_rd, CAP);
    step(8'h40, 1, 32'hFFFF_FFFF); step(8'h40, 0, 0); check("R10 missing channel", last_rd, 0);
    step(8'h1C, 1, 32'hFFFF_FFFF); step(8'h1C, 0, 0); check("R10 gap slot", last_rd, 0);

    // R3 tick spacing with reload 2: ch0 reload 0, restart, irq every 3 clocks
    step(8'h04, 1, 2);
    step(8'h00, 1, 0);
    step(8'h14, 1, 0);
    step(8'h18, 1, 32'hB);
    n = 0;
    for (int j = 0; j < 12; j++) begin
      step(8'h10, 0, 0);
      n += int'(last_irq[0]);
    end
    check("R3 tick every reload+1", n, 4);
    step(8'h18, 1, 32'h10);
    step(8'h04, 1, 0);

    // constrained random mix
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] a;
      logic [31:0] d;
      bit wr;
      int w = $urandom_range(0, 4);
      int s = $urandom_range(0, 3);
      a = 8'((w << 4) | (s << 2));
      wr = ($urandom_range(0, 9) < 3);
      if (s == 0) d = $urandom_range(0, 12);
      else if (s == 1) d = (w == 0) ? $urandom_range(0, 3) : $urandom_range(0, 6);
      else d = $urandom & 32'h7F;
      if ($urandom_range(0, 15) == 0) d = d | 32'hFFFF_0000;
      if (s == 0 && w != 0 && d > 32'hFFFF) d = d & 32'h3;
      step(a, wr, d);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule